// File: doc/BRIEF.md
# Interrupt Input Redirection Unit

This block turns up to 24 device interrupt lines into interrupt messages aimed at a set of processors. Software programs one 64-bit redirection entry per line. The entry holds the vector that the message carries, an 8-bit mask that selects the target processors, the trigger mode, the active polarity and a mask bit. The lines have no fixed ranking among themselves. Urgency is set only by the vector that software assigns to each line.

Software reaches the entries through an index register and a 32-bit data window. Each entry takes up two consecutive words: the even word holds the low half and the odd word the high half. Messages leave on a valid/ready output port.

An edge-mode line sends one message for each transition from inactive to active. A level-mode line sends one message and then stays silent until an end-of-interrupt that names its vector is received. If the line is still active at that point, it fires again. When several lines are ready in the same cycle, a round-robin arbiter picks the next one to send.

Top module: `irq_redirect_unit`

## Requirements
- R1: After reset every entry reads back with only the mask bit (bit 16 of the low word) set, and the high word reads zero. No message is valid.
- R2: The low word of an entry holds the vector in bits 7:0, active-low polarity in bit 13 and level trigger in bit 15 (1 means level). The high word holds the processor mask in bits 31:24 (entry bits 63:56). Every other bit reads as zero, whatever value was written to it.
- R3: While an entry's mask bit is set, its line produces no message.
- R4: An edge-mode line produces exactly one message per inactive-to-active transition, however long it then stays active.
- R5: A level-mode line produces one message and then no more while it stays active. An end-of-interrupt carrying a different vector has no effect on it.
- R6: An end-of-interrupt whose vector matches a level-mode entry re-arms that entry. If the line is still active, a new message follows. If the line is inactive, no message follows.
- R7: With bit 13 set, the line counts as active when low, and the high-to-low transition is the edge.
- R8: When several lines are ready at once, the grant goes to the first ready line after the most recently granted line, in ascending order with wrap-around. The search starts at line 0 after reset.
- R9: Once a message is valid, the valid signal, the vector and the processor mask stay unchanged until ready is seen.
- R10: Each message carries the vector and processor mask of the entry whose line raised it.
- R11: With the register select low, reads return the index register. A window access whose index points past the last entry reads zero and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | NUM_LINES | Interrupt lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the index register, 1 selects the data window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| msg_valid | output | 1 | Interrupt message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message processor mask |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |

## Verification
The assertions check the following on every cycle:
- The grant is at most one-hot and is never given to a line that is not ready or is masked.
- A granted level entry holds its remote-pending state.
- A granted edge request is consumed.
- A stalled message stays stable until it is accepted.

Only the bench scenarios can show the rest:
- the exact number of messages per edge train and per end-of-interrupt sequence;
- the rotating order that resolves simultaneous requests;
- polarity inversion;
- that reserved bits and out-of-range indices are inert.

The bench also keeps a behavioural model and compares it with the outputs on every cycle.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int VEC_W    = 8;
  localparam int DEST_W   = 8;
  localparam int POL_BIT  = 13;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              level;
    logic              act_low;
    logic [VEC_W-1:0]  vec;
  } entry_t;

  localparam entry_t ENTRY_RST = '{dest: '0, mask: 1'b1, level: 1'b0, act_low: 1'b0, vec: '0};

  function automatic logic [31:0] lo_word(entry_t e);
    logic [31:0] w;
    w = '0;
    w[VEC_W-1:0] = e.vec;
    w[POL_BIT]   = e.act_low;
    w[TRIG_BIT]  = e.level;
    w[MASK_BIT]  = e.mask;
    return w;
  endfunction

  function automatic logic [31:0] hi_word(entry_t e);
    logic [31:0] w;
    w = '0;
    w[31 -: DEST_W] = e.dest;
    return w;
  endfunction

  function automatic entry_t apply_lo(entry_t e, logic [31:0] w);
    entry_t r;
    r         = e;
    r.vec     = w[VEC_W-1:0];
    r.act_low = w[POL_BIT];
    r.level   = w[TRIG_BIT];
    r.mask    = w[MASK_BIT];
    return r;
  endfunction

  function automatic entry_t apply_hi(entry_t e, logic [31:0] w);
    entry_t r;
    r      = e;
    r.dest = w[31 -: DEST_W];
    return r;
  endfunction
endpackage

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic             grant,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vec,
  output entry_t           cfg,
  output logic             ready
);
  logic act, prev_act, edge_req, edge_now, eoi_hit, remote_pend;

  assign act      = pin ^ cfg.act_low;
  assign edge_now = act & ~prev_act & ~cfg.mask;
  assign eoi_hit  = eoi_valid & cfg.level & (eoi_vec == cfg.vec);
  assign ready    = ~cfg.mask & (cfg.level ? (act & ~remote_pend) : edge_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg         <= ENTRY_RST;
      prev_act    <= 1'b0;
      edge_req    <= 1'b0;
      remote_pend <= 1'b0;
    end else begin
      prev_act <= act;
      if (wr_lo)      cfg <= apply_lo(cfg, wdata);
      else if (wr_hi) cfg <= apply_hi(cfg, wdata);
      if (cfg.level)               edge_req <= 1'b0;
      else if (edge_now)           edge_req <= 1'b1;
      else if (grant || cfg.mask)  edge_req <= 1'b0;
      if (grant && cfg.level)      remote_pend <= 1'b1;
      else if (eoi_hit)            remote_pend <= 1'b0;
    end
  end

  // R3: a masked entry is never granted
  p_masked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !cfg.mask);
  // R5: a granted level entry waits for its end-of-interrupt
  p_level_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cfg.level) |=> (remote_pend && !ready));
  // R4: a granted edge request is consumed unless a new edge arrives
  p_edge_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !cfg.level && !edge_now && !wr_lo) |=> !ready);
endmodule

// File: rtl/irq_rr_arb.sv
module irq_rr_arb #(
  parameter int N = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 advance,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] win
);
  localparam int PW = $clog2(N);
  logic [PW-1:0] last;
  logic          found;

  always_comb begin
    grant = '0;
    win   = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!found && advance && req[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        win        = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last <= PW'(N - 1);
    else if (found) last <= win;
  end

  // R8: at most one grant, and only to a requester
  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_has_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/irq_redirect_unit.sv
module irq_redirect_unit
  import irq_redir_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_pin,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [VEC_W-1:0]     msg_vector,
  output logic [DEST_W-1:0]    msg_dest,
  input  logic                 eoi_valid,
  input  logic [VEC_W-1:0]     eoi_vector
);
  localparam int WORDS = 2 * NUM_LINES;
  localparam int IW    = $clog2(WORDS);
  localparam int PW    = $clog2(NUM_LINES);

  logic [IW-1:0]        win_idx;
  logic [IW-2:0]        entry_sel;
  logic                 word_hi, in_range, load;
  logic [PW-1:0]        sel_safe, win;
  entry_t               cfg_arr [NUM_LINES];
  logic [NUM_LINES-1:0] ready_v, grant_v;

  assign entry_sel = win_idx[IW-1:1];
  assign word_hi   = win_idx[0];
  assign in_range  = (int'(entry_sel) < NUM_LINES);
  assign sel_safe  = in_range ? PW'(entry_sel) : '0;
  assign load      = !msg_valid || msg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 win_idx <= '0;
    else if (reg_wr && !reg_sel) win_idx <= reg_wdata[IW-1:0];
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit;
    assign hit = reg_wr && reg_sel && in_range && (int'(entry_sel) == i);
    irq_redir_entry u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (irq_pin[i]),
      .wr_lo     (hit && !word_hi),
      .wr_hi     (hit && word_hi),
      .wdata     (reg_wdata),
      .grant     (grant_v[i]),
      .eoi_valid (eoi_valid),
      .eoi_vec   (eoi_vector),
      .cfg       (cfg_arr[i]),
      .ready     (ready_v[i])
    );
  end

  irq_rr_arb #(.N(NUM_LINES)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (ready_v),
    .advance (load),
    .grant   (grant_v),
    .win     (win)
  );

  always_comb begin
    if (!reg_sel)      reg_rdata = {{(32-IW){1'b0}}, win_idx};
    else if (!in_range) reg_rdata = '0;
    else if (word_hi)  reg_rdata = hi_word(cfg_arr[sel_safe]);
    else               reg_rdata = lo_word(cfg_arr[sel_safe]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_dest   <= '0;
    end else if (load) begin
      msg_valid <= |grant_v;
      if (|grant_v) begin
        msg_vector <= cfg_arr[win].vec;
        msg_dest   <= cfg_arr[win].dest;
      end
    end
  end

  // R9: a stalled message holds its payload
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)));
endmodule

// File: tb/irq_redirect_unit_tb.sv
module irq_redirect_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_pin = '0;
  logic reg_wr = 0, reg_sel = 0, msg_ready = 1, eoi_valid = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msg_valid;
  logic [7:0] msg_vector, msg_dest, eoi_vector = '0;

  irq_redirect_unit #(.NUM_LINES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, n_acc = 0;
  int acc_vec[$];
  int acc_dest[$];

  // behavioural reference
  int m_vec[N], m_dest[N];
  bit m_mask[N], m_lvl[N], m_pol[N], m_prev[N], m_ereq[N], m_rirr[N], m_rdy[N];
  int m_idx, m_last, m_ovec, m_odest;
  bit m_ov;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_vec[i] = 0; m_dest[i] = 0; m_mask[i] = 1; m_lvl[i] = 0; m_pol[i] = 0;
        m_prev[i] = 0; m_ereq[i] = 0; m_rirr[i] = 0;
      end
      m_idx = 0; m_last = N - 1; m_ov = 0; m_ovec = 0; m_odest = 0;
    end else begin
      int g;
      bit ld;
      g = -1;
      ld = !m_ov || msg_ready;
      for (int i = 0; i < N; i++) begin
        bit a;
        a = irq_pin[i] ^ m_pol[i];
        m_rdy[i] = !m_mask[i] && (m_lvl[i] ? (a && !m_rirr[i]) : m_ereq[i]);
      end
      if (ld) begin
        for (int k = 1; k <= N; k++)
          if (g < 0 && m_rdy[(m_last + k) % N]) g = (m_last + k) % N;
        if (g >= 0) begin
          m_ov = 1; m_ovec = m_vec[g]; m_odest = m_dest[g]; m_last = g;
        end else m_ov = 0;
      end
      for (int i = 0; i < N; i++) begin
        bit a;
        a = irq_pin[i] ^ m_pol[i];
        if (m_lvl[i]) m_ereq[i] = 0;
        else if (a && !m_prev[i] && !m_mask[i]) m_ereq[i] = 1;
        else if (g == i || m_mask[i]) m_ereq[i] = 0;
        if (g == i && m_lvl[i]) m_rirr[i] = 1;
        else if (eoi_valid && m_lvl[i] && eoi_vector == m_vec[i][7:0]) m_rirr[i] = 0;
        m_prev[i] = a;
      end
      if (reg_wr) begin
        if (!reg_sel) m_idx = int'(reg_wdata[5:0]);
        else if (m_idx / 2 < N) begin
          if (m_idx % 2 == 0) begin
            m_vec[m_idx/2] = int'(reg_wdata[7:0]); m_pol[m_idx/2] = reg_wdata[13];
            m_lvl[m_idx/2] = reg_wdata[15];        m_mask[m_idx/2] = reg_wdata[16];
          end else m_dest[m_idx/2] = int'(reg_wdata[31:24]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison and acceptance log, away from the clock edge
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      check(msg_valid == m_ov, "R9 model valid", int'(msg_valid), int'(m_ov));
      if (m_ov) begin
        check(msg_vector == m_ovec[7:0], "R10 model vector", int'(msg_vector), m_ovec);
        check(msg_dest == m_odest[7:0], "R10 model dest", int'(msg_dest), m_odest);
      end
      if (msg_valid && msg_ready) begin
        n_acc++; acc_vec.push_back(int'(msg_vector)); acc_dest.push_back(int'(msg_dest));
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask
  task automatic wr(input bit sel, input logic [31:0] d);
    step(); reg_wr = 1; reg_sel = sel; reg_wdata = d; step(); reg_wr = 0;
  endtask
  task automatic prog(input int e, input logic [31:0] lo, input logic [31:0] hi);
    wr(0, 2*e); wr(1, lo); wr(0, 2*e+1); wr(1, hi);
  endtask
  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    wr(0, idx); reg_sel = 1; #1;
    check(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
  endtask
  task automatic eoi(input logic [7:0] v);
    step(); eoi_valid = 1; eoi_vector = v; step(); eoi_valid = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, v;
    step(3); rst_n = 1; step(2);
    // R1 reset state
    check(msg_valid == 0, "R1 no message", int'(msg_valid), 0);
    rd(0, 32'h0001_0000, "R1 entry0 low");
    rd(1, 32'h0, "R1 entry0 high");
    rd(46, 32'h0001_0000, "R1 entry23 low");
    // R11 index readback and out-of-range window
    wr(0, 46); reg_sel = 0; #1;
    check(reg_rdata == 32'd46, "R11 index readback", int'(reg_rdata), 46);
    wr(0, 50); wr(1, 32'hFFFF_FFFF); reg_sel = 1; #1;
    check(reg_rdata == 0, "R11 out of range read", int'(reg_rdata), 0);
    rd(0, 32'h0001_0000, "R11 entry untouched");
    // R2 layout with reserved bits written as ones
    prog(3, 32'hFFFE_5F41, 32'h05FF_FFFF);
    rd(6, 32'h0000_0041, "R2 low word");
    rd(7, 32'h0500_0000, "R2 high word");
    // R4 edge trains
    base = n_acc;
    for (int p = 0; p < 3; p++) begin irq_pin[3] = 1; step(2); irq_pin[3] = 0; step(2); end
    step(4);
    check(n_acc - base == 3, "R4 three edges", n_acc - base, 3);
    check(acc_dest[$] == 5, "R10 dest", acc_dest[$], 5);
    check(acc_vec[$] == 'h41, "R10 vector", acc_vec[$], 'h41);
    base = n_acc; irq_pin[3] = 1; step(12); irq_pin[3] = 0; step(3);
    check(n_acc - base == 1, "R4 long high one message", n_acc - base, 1);
    // R3 masked
    prog(3, 32'h0001_0041, 32'h0500_0000);
    base = n_acc;
    for (int p = 0; p < 3; p++) begin irq_pin[3] = 1; step(2); irq_pin[3] = 0; step(2); end
    step(3);
    check(n_acc - base == 0, "R3 masked silent", n_acc - base, 0);
    rd(6, 32'h0001_0041, "R3 mask readback");
    // R5/R6 level
    prog(5, 32'h0000_8062, 32'h8000_0000);
    base = n_acc; irq_pin[5] = 1; step(10);
    check(n_acc - base == 1, "R5 one level message", n_acc - base, 1);
    eoi(8'h63); step(5);
    check(n_acc - base == 1, "R5 foreign eoi ignored", n_acc - base, 1);
    eoi(8'h62); step(5);
    check(n_acc - base == 2, "R6 eoi refires", n_acc - base, 2);
    check(acc_dest[$] == 'h80, "R10 level dest", acc_dest[$], 'h80);
    irq_pin[5] = 0; step(2); eoi(8'h62); step(5);
    check(n_acc - base == 2, "R6 inactive no refire", n_acc - base, 2);
    // R7 active-low edge
    irq_pin[7] = 1; step();
    prog(7, 32'h0000_2070, 32'h0);
    base = n_acc; step(5);
    check(n_acc - base == 0, "R7 idle high silent", n_acc - base, 0);
    irq_pin[7] = 0; step(4);
    check(n_acc - base == 1, "R7 falling edge", n_acc - base, 1);
    check(acc_vec[$] == 'h70, "R7 vector", acc_vec[$], 'h70);
    // R8/R9 arbitration and hold
    prog(8, 32'h0000_8080, 32'h0100_0000);
    prog(9, 32'h0000_8081, 32'h0200_0000);
    prog(10, 32'h0000_8082, 32'h0400_0000);
    msg_ready = 0; base = n_acc;
    irq_pin[10:8] = 3'b111; step(4);
    check(msg_valid == 1 && msg_vector == 8'h80, "R8 first after last grant", int'(msg_vector), 'h80);
    v = int'(msg_vector); step(3);
    check(msg_valid == 1 && int'(msg_vector) == v, "R9 stalled hold", int'(msg_vector), v);
    msg_ready = 1; step(6);
    check(n_acc - base == 3, "R8 all served", n_acc - base, 3);
    check(acc_vec[$-2] == 'h80 && acc_vec[$-1] == 'h81 && acc_vec[$] == 'h82,
          "R8 rotating order", acc_vec[$-1], 'h81);
    // R8 wrap-around: after line 10, line 20 precedes line 1
    prog(1, 32'h0000_8031, 32'h0);
    prog(20, 32'h0000_8094, 32'h0);
    base = n_acc; irq_pin[1] = 1; irq_pin[20] = 1; step(6);
    check(n_acc - base == 2, "R8 wrap count", n_acc - base, 2);
    check(acc_vec[$-1] == 'h94 && acc_vec[$] == 'h31, "R8 wrap order", acc_vec[$-1], 'h94);
    step(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule